// File: doc/BRIEF.md
# Windowed Register File Address Translator

This block turns register references into physical targets inside a 256-entry register space. A reference is either a full 8-bit register address or a short 4-bit working-register number. Working numbers are resolved through window pointers held in the block. The resolved 8-bit address is then classified by its upper nibble, which is the group number, and its lower nibble, which is the slot within the group. Addresses 0 to 223 are general-purpose registers. Group 14 (224 to 239) is the system group. Group 15 (240 to 255) is redirected to one of 64 pages of 16 registers, chosen by a 6-bit page pointer.

Two pointer bytes set the working windows. In the single-window mode the 16-register window starts at the even 8-register group equal to or just below the stored group. In the twin-window mode working registers 0 to 7 sit on the first pointer's group and working registers 8 to 15 sit on the second pointer's group. Pointer and page commands arrive on a plain command port. Each takes effect for requests presented on the clock cycle after it is accepted.

Requests flow through a valid/ready pair. Translation is combinational, so a response is valid in the same cycle as its request. Back-pressure from `rsp_ready` passes straight to `req_ready`. While a response is stalled, the requester must hold the request stable. The response then stays stable too, provided no pointer command is issued in the meantime.

Top module: `reg_window_xlate`

## Requirements
- R1: A direct request (req_working=0) to an address below 224 yields rsp_kind=0 (general) with rsp_index equal to the address and rsp_page=0.
- R2: An address in 224..239 yields rsp_kind=1 (system) with rsp_index equal to the low nibble and rsp_page=0.
- R3: An address in 240..255 yields rsp_kind=2 (paged) with rsp_index equal to the low nibble and rsp_page equal to the current page pointer.
- R4: rsp_illegal is 1 exactly when a direct request targets 208..223. Working-register requests never raise it, and the kind and index are still reported.
- R5: Pointer bytes read back with bits 7:3 as the stored group, bit 2 as the mode and bits 1:0 always 0, whatever the written data.
- R6: In single-window mode (mode bit 0), working register w (req_addr[3:0]) resolves to 16*floor(g0/2)+w, where g0 is the first pointer's group.
- R7: In twin-window mode (mode bit 1), w in 0..7 resolves to 8*g0+w and w in 8..15 resolves to 8*g1+(w-8).
- R8: cmd_op 1 (set first, data bits 7:3 to g0) and cmd_op 2 (set second, data bits 7:3 to g1) set the mode bit. cmd_op 0 (set single, data bits 7:3 to g0) clears it. Both pointer bytes show the same mode bit.
- R9: cmd_op 3 stores cmd_data[7:2] as the page pointer. page_byte shows it with bits 1:0 at 0, and it persists until it is rewritten.
- R10: After reset both pointer groups, the page pointer and the mode bit are 0.
- R11: An accepted command affects requests from the next clock cycle on, and not requests in its own cycle.
- R12: rsp_valid equals req_valid and req_ready equals rsp_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Pointer command strobe |
| cmd_op | input | 2 | 0 set single, 1 set first, 2 set second, 3 set page |
| cmd_data | input | 8 | Command data byte |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted |
| req_working | input | 1 | 1 means req_addr[3:0] is a working-register number |
| req_addr | input | 8 | Direct address or working number |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Downstream ready |
| rsp_kind | output | 2 | 0 general, 1 system, 2 paged |
| rsp_index | output | 8 | Target index |
| rsp_page | output | 6 | Page number for paged targets, else 0 |
| rsp_illegal | output | 1 | Direct access to the hidden group |
| ptr0_byte | output | 8 | First pointer byte |
| ptr1_byte | output | 8 | Second pointer byte |
| page_byte | output | 8 | Page pointer byte |

## Verification
On every cycle the assertions check the following: the fixed zero bits of the pointer bytes, the handshake pass-through, the hidden-group flag on direct requests, and the system and paged decodes against the page byte. They also check how each command kind changes the pointer bytes one cycle later. Only the bench scenarios show the even-group alignment of the single window and the twin-window split at working register 8, with concrete values. The same holds for the rule that a command never alters a request made in its own cycle.

// File: rtl/rwx_pkg.sv
package rwx_pkg;
  localparam int ADDR_W    = 8;
  localparam int NIB_W     = ADDR_W / 2;
  localparam int GRP_W     = ADDR_W - 3;
  localparam int PAGE_W    = ADDR_W - 2;
  localparam logic [NIB_W-1:0] HIDDEN_GRP = 4'd13;
  localparam logic [NIB_W-1:0] SYS_GRP    = 4'd14;
  localparam logic [NIB_W-1:0] TOP_GRP    = 4'd15;

  typedef enum logic [1:0] {
    OP_SET_SINGLE = 2'd0,
    OP_SET_FIRST  = 2'd1,
    OP_SET_SECOND = 2'd2,
    OP_SET_PAGE   = 2'd3
  } ptr_op_e;

  typedef enum logic [1:0] {
    TGT_GPR  = 2'd0,
    TGT_SYS  = 2'd1,
    TGT_PAGE = 2'd2
  } tgt_kind_e;
endpackage

// File: rtl/rwx_ptr_regs.sv
module rwx_ptr_regs
  import rwx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_data,
  output logic [GRP_W-1:0]  grp0,
  output logic [GRP_W-1:0]  grp1,
  output logic              twin,
  output logic [PAGE_W-1:0] page
);
  ptr_op_e op;
  assign op = ptr_op_e'(cmd_op);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp0 <= '0;
      grp1 <= '0;
      twin <= 1'b0;
      page <= '0;
    end else if (cmd_valid) begin
      unique case (op)
        OP_SET_SINGLE: begin
          grp0 <= cmd_data[ADDR_W-1 -: GRP_W];
          twin <= 1'b0;
        end
        OP_SET_FIRST: begin
          grp0 <= cmd_data[ADDR_W-1 -: GRP_W];
          twin <= 1'b1;
        end
        OP_SET_SECOND: begin
          grp1 <= cmd_data[ADDR_W-1 -: GRP_W];
          twin <= 1'b1;
        end
        OP_SET_PAGE: page <= cmd_data[ADDR_W-1 -: PAGE_W];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rwx_wr_map.sv
module rwx_wr_map
  import rwx_pkg::*;
(
  input  logic [GRP_W-1:0]  grp0,
  input  logic [GRP_W-1:0]  grp1,
  input  logic              twin,
  input  logic [NIB_W-1:0]  wnum,
  output logic [ADDR_W-1:0] abs_addr
);
  always_comb begin
    if (!twin)
      abs_addr = {grp0[GRP_W-1:1], wnum};
    else if (!wnum[NIB_W-1])
      abs_addr = {grp0, wnum[NIB_W-2:0]};
    else
      abs_addr = {grp1, wnum[NIB_W-2:0]};
  end
endmodule

// File: rtl/rwx_decode.sv
module rwx_decode
  import rwx_pkg::*;
(
  input  logic [ADDR_W-1:0] abs_addr,
  input  logic              direct,
  input  logic [PAGE_W-1:0] page,
  output tgt_kind_e         kind,
  output logic [ADDR_W-1:0] index,
  output logic [PAGE_W-1:0] page_out,
  output logic              illegal
);
  logic [NIB_W-1:0] grp;
  logic [NIB_W-1:0] slot;
  assign grp  = abs_addr[ADDR_W-1 -: NIB_W];
  assign slot = abs_addr[NIB_W-1:0];

  always_comb begin
    page_out = '0;
    if (grp == TOP_GRP) begin
      kind     = TGT_PAGE;
      index    = {{(ADDR_W-NIB_W){1'b0}}, slot};
      page_out = page;
    end else if (grp == SYS_GRP) begin
      kind  = TGT_SYS;
      index = {{(ADDR_W-NIB_W){1'b0}}, slot};
    end else begin
      kind  = TGT_GPR;
      index = abs_addr;
    end
    illegal = direct && (grp == HIDDEN_GRP);
  end
endmodule

// File: rtl/reg_window_xlate.sv
module reg_window_xlate
  import rwx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic [7:0] cmd_data,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_working,
  input  logic [7:0] req_addr,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [1:0] rsp_kind,
  output logic [7:0] rsp_index,
  output logic [5:0] rsp_page,
  output logic       rsp_illegal,
  output logic [7:0] ptr0_byte,
  output logic [7:0] ptr1_byte,
  output logic [7:0] page_byte
);
  logic [GRP_W-1:0]  grp0, grp1;
  logic              twin;
  logic [PAGE_W-1:0] page;
  logic [ADDR_W-1:0] wr_abs, abs_addr;
  tgt_kind_e         kind;

  rwx_ptr_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .grp0(grp0), .grp1(grp1), .twin(twin), .page(page)
  );

  rwx_wr_map u_map (
    .grp0(grp0), .grp1(grp1), .twin(twin), .wnum(req_addr[NIB_W-1:0]),
    .abs_addr(wr_abs)
  );

  assign abs_addr = req_working ? wr_abs : req_addr;

  rwx_decode u_dec (
    .abs_addr(abs_addr), .direct(!req_working), .page(page),
    .kind(kind), .index(rsp_index), .page_out(rsp_page), .illegal(rsp_illegal)
  );

  assign rsp_kind  = kind;
  assign rsp_valid = req_valid;
  assign req_ready = rsp_ready;
  assign ptr0_byte = {grp0, twin, 2'b00};
  assign ptr1_byte = {grp1, twin, 2'b00};
  assign page_byte = {page, 2'b00};
endmodule

// File: rtl/rwx_checker.sv
module rwx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic [7:0] cmd_data,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_working,
  input logic [7:0] req_addr,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [1:0] rsp_kind,
  input logic [7:0] rsp_index,
  input logic [5:0] rsp_page,
  input logic       rsp_illegal,
  input logic [7:0] ptr0_byte,
  input logic [7:0] ptr1_byte,
  input logic [7:0] page_byte
);
  assert_low_bits_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ptr0_byte[1:0] == 2'b00 && ptr1_byte[1:0] == 2'b00 && page_byte[1:0] == 2'b00);

  assert_mode_shared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ptr0_byte[2] == ptr1_byte[2]);

  assert_handshake_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == req_valid && req_ready == rsp_ready);

  assert_hidden_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_illegal == (!req_working && req_addr[7:4] == 4'd13));

  assert_sys_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !req_working && req_addr[7:4] == 4'd14)
      |-> (rsp_kind == 2'd1 && rsp_index == {4'd0, req_addr[3:0]} && rsp_page == 6'd0));

  assert_page_decode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == 2'd2) |-> rsp_page == page_byte[7:2]);

  assert_page_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd3) |=> page_byte[7:2] == $past(cmd_data[7:2]));

  assert_twin_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 2'd1 || cmd_op == 2'd2)) |=> ptr0_byte[2]);

  assert_single_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd0) |=> (!ptr0_byte[2] && ptr0_byte[7:3] == $past(cmd_data[7:3])));

  assert_no_cmd_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ($stable(ptr0_byte) && $stable(ptr1_byte) && $stable(page_byte)));
endmodule

bind reg_window_xlate rwx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_data(cmd_data), .req_valid(req_valid), .req_ready(req_ready),
  .req_working(req_working), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_kind(rsp_kind), .rsp_index(rsp_index),
  .rsp_page(rsp_page), .rsp_illegal(rsp_illegal), .ptr0_byte(ptr0_byte),
  .ptr1_byte(ptr1_byte), .page_byte(page_byte)
);

// File: tb/tb_reg_window_xlate.sv
`timescale 1ns/1ps
module tb_reg_window_xlate;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_data = 8'd0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_working = 1'b0;
  logic [7:0] req_addr = 8'd0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b0;
  logic [1:0] rsp_kind;
  logic [7:0] rsp_index;
  logic [5:0] rsp_page;
  logic       rsp_illegal;
  logic [7:0] ptr0_byte, ptr1_byte, page_byte;

  reg_window_xlate dut (.*);

  always #4 clk = ~clk;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  // behavioural model state
  int m_g0 = 0, m_g1 = 0, m_pg = 0;
  bit m_twin = 1'b0;

  task automatic check(input string tag);
    int abs_a, e_kind, e_idx, e_page, w;
    bit e_ill;
    string t;
    if (req_working) begin
      w = int'(req_addr[3:0]);
      if (!m_twin)      abs_a = (m_g0 / 2) * 16 + w;
      else if (w < 8)   abs_a = m_g0 * 8 + w;
      else              abs_a = m_g1 * 8 + w - 8;
    end else abs_a = int'(req_addr);
    e_page = 0;
    if (abs_a >= 240)      begin e_kind = 2; e_idx = abs_a - 240; e_page = m_pg; end
    else if (abs_a >= 224) begin e_kind = 1; e_idx = abs_a - 224; end
    else                   begin e_kind = 0; e_idx = abs_a; end
    e_ill = !req_working && abs_a >= 208 && abs_a < 224;
    if (tag != "") t = tag;
    else if (req_working) t = m_twin ? "R7" : "R6";
    else if (e_kind == 2) t = "R3";
    else if (e_kind == 1) t = "R2";
    else if (e_ill) t = "R4";
    else t = "R1";
    vectors++;
    if (int'(rsp_kind) != e_kind || int'(rsp_index) != e_idx ||
        int'(rsp_page) != e_page || rsp_illegal != e_ill) begin
      fails++;
      $display("FAIL %s: kind/index/page/ill got %0d/%0d/%0d/%0d exp %0d/%0d/%0d/%0d",
               t, rsp_kind, rsp_index, rsp_page, rsp_illegal, e_kind, e_idx, e_page, e_ill);
    end
    vectors++;
    if (ptr0_byte != {m_g0[4:0], m_twin, 2'b00} || ptr1_byte != {m_g1[4:0], m_twin, 2'b00} ||
        page_byte != {m_pg[5:0], 2'b00}) begin
      fails++;
      $display("FAIL R5/R8/R9: ptr0/ptr1/page got %h/%h/%h exp %h/%h/%h", ptr0_byte, ptr1_byte,
               page_byte, {m_g0[4:0], m_twin, 2'b00}, {m_g1[4:0], m_twin, 2'b00}, {m_pg[5:0], 2'b00});
    end
    vectors++;
    if (rsp_valid != req_valid || req_ready != rsp_ready) begin
      fails++;
      $display("FAIL R12: valid/ready got %0d/%0d exp %0d/%0d", rsp_valid, req_ready, req_valid, rsp_ready);
    end
  endtask

  task automatic step(input bit cv, input logic [1:0] op, input logic [7:0] cd,
                      input bit rv, input bit rw, input logic [7:0] ra, input bit rr,
                      input string tag);
    @(negedge clk);
    cmd_valid = cv; cmd_op = op; cmd_data = cd;
    req_valid = rv; req_working = rw; req_addr = ra; rsp_ready = rr;
    #1 check(tag);  // a command in this cycle must not show yet (R11)
    @(posedge clk);
    if (cv) begin
      case (op)
        2'd0: begin m_g0 = int'(cd[7:3]); m_twin = 1'b0; end
        2'd1: begin m_g0 = int'(cd[7:3]); m_twin = 1'b1; end
        2'd2: begin m_g1 = int'(cd[7:3]); m_twin = 1'b1; end
        default: m_pg = int'(cd[7:2]);
      endcase
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state, direct address 0 and working r0 both land on 0
    step(0, 0, 0, 1, 0, 8'd0, 1, "R10");
    step(0, 0, 0, 1, 1, 8'd0, 1, "R10");
    // R1, R2, R3, R4 boundaries
    step(0, 0, 0, 1, 0, 8'd207, 1, "R1");
    step(0, 0, 0, 1, 0, 8'd208, 1, "R4");
    step(0, 0, 0, 1, 0, 8'd223, 0, "R4");
    step(0, 0, 0, 1, 0, 8'd224, 1, "R2");
    step(0, 0, 0, 1, 0, 8'd239, 1, "R2");
    step(0, 0, 0, 1, 0, 8'd240, 1, "R3");
    // R11: page write, same-cycle request still sees page 0, next sees 5
    step(1, 2'd3, 8'h17, 1, 0, 8'd242, 1, "R11");
    step(0, 0, 0, 1, 0, 8'd242, 1, "R11");
    // R9: low bits of page data dropped, page 63
    step(1, 2'd3, 8'hFF, 0, 0, 8'd255, 0, "R9");
    step(0, 0, 0, 1, 0, 8'd255, 1, "R9");
    // R5/R8: first pointer with all ones, low bits read zero, twin mode
    step(1, 2'd1, 8'hFF, 0, 0, 8'd0, 1, "R5");
    step(0, 0, 0, 1, 1, 8'd3, 1, "R7");
    // R7: second pointer group 4 (base 32), working 12 -> 36
    step(1, 2'd2, 8'd32, 0, 0, 8'd0, 1, "R8");
    step(0, 0, 0, 1, 1, 8'd12, 1, "R7");
    step(1, 2'd1, 8'd96, 0, 0, 8'd0, 1, "R8");
    step(0, 0, 0, 1, 1, 8'd5, 1, "R7");
    step(0, 0, 0, 1, 1, 8'd8, 1, "R7");
    // R6: single set with group 3 acts as group 2 (base 16); working 5 -> 21
    step(1, 2'd0, 8'h18, 0, 0, 8'd0, 1, "R8");
    step(0, 0, 0, 1, 1, 8'd5, 1, "R6");
    step(0, 0, 0, 1, 1, 8'd15, 1, "R6");
    // R4: working request into group 13 is not flagged
    step(1, 2'd0, 8'd208, 0, 0, 8'd0, 1, "R6");
    step(0, 0, 0, 1, 1, 8'd4, 1, "R4");
    // mixed stimulus compared against the model on every clock
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step((r[1:0] == 2'b00), r[3:2], r[11:4], r[12], r[13], r[21:14], r[22], "");
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule